// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block derives the 16x oversampling strobe of a serial receiver and transmitter from one of two clock sources. The first is the block's own clock, which supplies a pulse in every cycle. The second is an external clock that has already been synchronised into a one-cycle enable. Every source pulse first passes through a fixed divide-by-two stage. In the generator modes the result then passes through a power-of-four prescaler and an 8-bit divisor. In the direct modes the halved source pulse is used as the strobe. A second output marks each bit period by pulsing on every sixteenth oversampling strobe.

A single configuration word sets the divisor, the prescaler select and the source select. A write takes effect on the clock edge where it is presented, and the same write restarts every counter. This makes the new rate predictable from the cycle after the write.

A combinational encoder is placed beside the generator. It converts a requested raw quotient into the prescaler and divisor pair that software would load. Quotients that are too large for any setting saturate to the slowest pair.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held and after its release, both tick outputs are low. The reset configuration is divisor 1, prescaler select 0 and source select 01, which gives a strobe every 2 cycles.
- R2: The configuration word carries the divisor in bits 7:0, the prescaler select in bits 9:8 and the source select in bits 11:10. Prescaler select values 0, 1, 2 and 3 divide by 1, 4, 16 and 64.
- R3: Source select 00 uses the internal clock directly. 01 uses the internal clock through the prescaler and divisor. 10 uses the external enable directly. 11 uses the external enable through the prescaler and divisor. The internal source supplies a pulse in every cycle. The external source supplies a pulse only in cycles where `ext_en` is high.
- R4: Counting source pulses since the last restart, `baud_tick` goes high for exactly one cycle after each multiple of N pulses. N is 2·P·D in the generator modes, where P is the prescale factor and D is the divisor. N is 2 in the direct modes. The tick appears in the cycle after the clock edge that counted the completing pulse, so two strobes are never adjacent.
- R5: A divisor value of 0 behaves exactly like a divisor of 1.
- R6: A clock edge with `cfg_we` high loads the word, clears the source, prescaler, divisor and bit counters, and forces both ticks low in the following cycle. A pulse present at that edge is not counted.
- R7: `bit_tick` is high for one cycle together with every sixteenth `baud_tick` after a restart, and at no other time.
- R8: In the external modes, a cycle with `ext_en` low advances no counter and produces no tick in the following cycle.
- R9: The encoder halves `req_quot` and picks the smallest prescaler select s for which the halved value shifted right by 2·s is below 256. It outputs that shifted value as the divisor.
- R10: When the halved quotient is 16384 or more, the encoder outputs divisor 0xFF with prescaler select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal source |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe, restarts the counters |
| cfg_wdata | input | 12 | Configuration word: source select, prescaler select, divisor |
| ext_en | input | 1 | Synchronised external clock enable |
| req_quot | input | QUOT_W (16) | Raw quotient presented to the encoder |
| enc_div | output | 8 | Encoder divisor result |
| enc_psel | output | 2 | Encoder prescaler select result |
| baud_tick | output | 1 | One-cycle 16x oversampling strobe |
| bit_tick | output | 1 | One-cycle strobe on every sixteenth baud tick |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, a 2-bit prescaler select and a 16-bit quotient. With these values, every prescaler setting and the saturation threshold at quotient 32768 lie inside the input range. The reset period of 2 cycles and the small divisors used in the tests keep strobe periods short, so many bit-rate strobes fall within each configuration's run. Restarts mid-period, sparse and absent external enables, and the divisor-zero case are all covered by the same cycle model.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int DIV_W  = 8;
  localparam int PSEL_W = 2;
  localparam int SRC_W  = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_INT_DIRECT = 2'b00,
    SRC_INT_GEN    = 2'b01,
    SRC_EXT_DIRECT = 2'b10,
    SRC_EXT_GEN    = 2'b11
  } src_mode_e;

  // Field order sets the bit positions of the configuration word (R2)
  typedef struct packed {
    src_mode_e          src;
    logic [PSEL_W-1:0]  psel;
    logic [DIV_W-1:0]   div;
  } baud_cfg_t;

  localparam int CFG_W = $bits(baud_cfg_t);

  function automatic logic src_is_ext(input src_mode_e m);
    return (m == SRC_EXT_DIRECT) || (m == SRC_EXT_GEN);
  endfunction

  function automatic logic src_uses_gen(input src_mode_e m);
    return (m == SRC_INT_GEN) || (m == SRC_EXT_GEN);
  endfunction

endpackage

// File: rtl/baud_src_stage.sv
// Source selection and fixed divide-by-two stage
module baud_src_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic use_ext,
  input  logic ext_en,
  output logic half_hit
);
  logic pulse;
  logic half_q;

  assign pulse    = use_ext ? ext_en : 1'b1;
  assign half_hit = pulse & half_q & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (restart) half_q <= 1'b0;
    else if (pulse)   half_q <= ~half_q;
  end
endmodule

// File: rtl/baud_prescaler.sv
// Power-of-four prescaler: passes one of every 4**psel input steps
module baud_prescaler #(
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [PSEL_W-1:0] psel,
  output logic              pre_hit
);
  localparam int NSTEP = 1 << PSEL_W;
  localparam int CNT_W = 2 * (NSTEP - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  function automatic logic [CNT_W-1:0] last_count(input logic [PSEL_W-1:0] p);
    logic [CNT_W:0] span;
    span = (CNT_W+1)'(1) << (2 * p);
    return CNT_W'(span - 1'b1);
  endfunction

  assign last    = last_count(psel);
  assign pre_hit = step & (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (step)    cnt_q <= pre_hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_divider.sv
// Programmable divisor; a zero divisor acts as one
module baud_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [DIV_W-1:0] div,
  output logic             div_hit
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  assign last    = last_count(div);
  assign div_hit = step & (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (step)    cnt_q <= div_hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_quot_enc.sv
// Quotient to prescaler/divisor encoder with saturation
module baud_quot_enc #(
  parameter int QUOT_W = 16,
  parameter int DIV_W  = 8,
  parameter int PSEL_W = 2
) (
  input  logic [QUOT_W-1:0] req_quot,
  output logic [DIV_W-1:0]  enc_div,
  output logic [PSEL_W-1:0] enc_psel
);
  localparam int NLVL = 1 << PSEL_W;
  localparam logic [QUOT_W:0] DIV_RANGE = (QUOT_W+1)'(1) << DIV_W;

  function automatic logic [PSEL_W+DIV_W-1:0] encode(input logic [QUOT_W-1:0] q);
    logic [QUOT_W-1:0] halved;
    logic [QUOT_W-1:0] shifted;
    logic              found;
    logic [DIV_W-1:0]  d;
    logic [PSEL_W-1:0] s;
    halved = q >> 1;
    found  = 1'b0;
    d      = '1;
    s      = '1;
    for (int lvl = 0; lvl < NLVL; lvl++) begin
      shifted = halved >> (2 * lvl);
      if (!found && ({1'b0, shifted} < DIV_RANGE)) begin
        found = 1'b1;
        d     = DIV_W'(shifted);
        s     = PSEL_W'(lvl);
      end
    end
    return {s, d};
  endfunction

  assign {enc_psel, enc_div} = encode(req_quot);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int                QUOT_W    = 16,
  parameter int                OVS       = 16,
  parameter logic [DIV_W-1:0]  RST_DIV   = 8'd1,
  parameter logic [PSEL_W-1:0] RST_PSEL  = 2'd0,
  parameter logic [SRC_W-1:0]  RST_SRC   = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ext_en,
  input  logic [QUOT_W-1:0] req_quot,
  output logic [DIV_W-1:0]  enc_div,
  output logic [PSEL_W-1:0] enc_psel,
  output logic              baud_tick,
  output logic              bit_tick
);
  localparam int OVS_W = $clog2(OVS);
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

  baud_cfg_t        cfg_q;
  logic             restart;
  logic             use_ext;
  logic             gen_path;
  logic [SRC_W-1:0] cur_src;
  logic             half_hit;
  logic             pre_hit;
  logic             div_hit;
  logic             rate_hit;
  logic             ovs_last;
  logic [OVS_W-1:0] ovs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.src  <= src_mode_e'(RST_SRC);
      cfg_q.psel <= RST_PSEL;
      cfg_q.div  <= RST_DIV;
    end else if (cfg_we) begin
      cfg_q <= baud_cfg_t'(cfg_wdata);
    end
  end

  assign restart  = cfg_we;
  assign use_ext  = src_is_ext(cfg_q.src);
  assign gen_path = src_uses_gen(cfg_q.src);
  assign cur_src  = cfg_q.src;

  baud_src_stage u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .use_ext  (use_ext),
    .ext_en   (ext_en),
    .half_hit (half_hit)
  );

  baud_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (half_hit),
    .psel    (cfg_q.psel),
    .pre_hit (pre_hit)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (pre_hit),
    .div     (cfg_q.div),
    .div_hit (div_hit)
  );

  baud_quot_enc #(.QUOT_W(QUOT_W), .DIV_W(DIV_W), .PSEL_W(PSEL_W)) u_enc (
    .req_quot (req_quot),
    .enc_div  (enc_div),
    .enc_psel (enc_psel)
  );

  assign rate_hit = gen_path ? div_hit : half_hit;
  assign ovs_last = (ovs_q == OVS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        ovs_q <= '0;
    else if (restart)  ovs_q <= '0;
    else if (rate_hit) ovs_q <= ovs_last ? '0 : ovs_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      baud_tick <= 1'b0;
      bit_tick  <= 1'b0;
    end else begin
      baud_tick <= rate_hit;
      bit_tick  <= rate_hit & ovs_last;
    end
  end
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int QUOT_W = 16,
  parameter int DIV_W  = 8,
  parameter int PSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              ext_en,
  input logic [1:0]        cur_src,
  input logic              baud_tick,
  input logic              bit_tick,
  input logic [QUOT_W-1:0] req_quot,
  input logic [DIV_W-1:0]  enc_div,
  input logic [PSEL_W-1:0] enc_psel
);
  localparam logic [QUOT_W:0] SAT_AT =
    (QUOT_W+1)'(2) << (DIV_W + 2 * ((1 << PSEL_W) - 1));

  logic [3:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         seen_q <= '0;
    else if (cfg_we)    seen_q <= '0;
    else if (baud_tick) seen_q <= seen_q + 1'b1;
  end

  a_r4_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!baud_tick && !bit_tick));

  a_r7_bit_with_baud: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> baud_tick);

  a_r7_sixteenth: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> (bit_tick == (seen_q == 4'd15)));

  a_r8_ext_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src[1] && !ext_en && !cfg_we) |=> !baud_tick);

  a_r9_smallest_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_psel != '0) |-> (enc_div[DIV_W-1:DIV_W-2] != 2'b00));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, req_quot} >= SAT_AT) |-> ((enc_div == '1) && (enc_psel == '1)));
endmodule

bind baud_tick_gen baud_tick_chk #(
  .QUOT_W (QUOT_W),
  .DIV_W  (baud_pkg::DIV_W),
  .PSEL_W (baud_pkg::PSEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .ext_en    (ext_en),
  .cur_src   (cur_src),
  .baud_tick (baud_tick),
  .bit_tick  (bit_tick),
  .req_quot  (req_quot),
  .enc_div   (enc_div),
  .enc_psel  (enc_psel)
);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
  localparam int QW = 16;
  localparam logic [11:0] RST_WORD = 12'b01_00_00000001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [11:0]   cfg_wdata = '0;
  logic          ext_en = 1'b0;
  logic [QW-1:0] req_quot = '0;
  logic [7:0]    enc_div;
  logic [1:0]    enc_psel;
  logic          baud_tick;
  logic          bit_tick;

  int unsigned checks = 0;
  int unsigned errors = 0;
  string       cur_tag = "R1";
  int unsigned dens = 0;

  // cycle model state
  logic [11:0] mcfg = RST_WORD;
  int unsigned k = 0;
  logic        exp_baud = 1'b0;
  logic        exp_bit = 1'b0;
  logic        pulse;

  always #4 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ext_en(ext_en), .req_quot(req_quot), .enc_div(enc_div),
    .enc_psel(enc_psel), .baud_tick(baud_tick), .bit_tick(bit_tick)
  );

  function automatic int unsigned period_of(input logic [11:0] c);
    int unsigned p;
    int unsigned d;
    p = 1 << (2 * c[9:8]);
    d = (c[7:0] == 8'd0) ? 1 : c[7:0];
    return c[10] ? 2 * p * d : 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcfg = RST_WORD; k = 0; exp_baud = 0; exp_bit = 0;
    end else if (cfg_we) begin
      mcfg = cfg_wdata; k = 0; exp_baud = 0; exp_bit = 0;
    end else begin
      pulse = mcfg[11] ? ext_en : 1'b1;
      exp_baud = 0; exp_bit = 0;
      if (pulse) begin
        k++;
        if (k % period_of(mcfg) == 0) begin
          exp_baud = 1;
          if (k % (16 * period_of(mcfg)) == 0) exp_bit = 1;
        end
      end
    end
  end

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: sample at negedge, then drive the next inputs
  task automatic cyc();
    @(negedge clk);
    check_bit(cur_tag, "baud_tick (R4)", baud_tick, exp_baud);
    check_bit(cur_tag, "bit_tick (R7)", bit_tick, exp_bit);
    cfg_we = 1'b0;
    ext_en = (($urandom % 100) < dens);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [11:0] w);
    cyc();
    cfg_wdata = w;
    cfg_we = 1'b1;
  endtask

  function automatic logic [9:0] ref_enc(input logic [QW-1:0] q);
    int unsigned h;
    h = q / 2;
    if (h < 256)        return {2'd0, 8'(h)};
    else if (h < 1024)  return {2'd1, 8'(h / 4)};
    else if (h < 4096)  return {2'd2, 8'(h / 16)};
    else if (h < 16384) return {2'd3, 8'(h / 64)};
    else                return {2'd3, 8'hFF};
  endfunction

  task automatic enc_check(input logic [QW-1:0] q);
    logic [9:0] e;
    @(negedge clk);
    req_quot = q;
    #1;
    e = ref_enc(q);
    checks++;
    if ({enc_psel, enc_div} !== e) begin
      errors++;
      $display("FAIL %s encoder q=%0d act=%0d/%0h exp=%0d/%0h",
               ((q / 2) >= 16384) ? "R10" : "R9", q, enc_psel, enc_div, e[9:8], e[7:0]);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (4) @(negedge clk);
    check_bit("R1", "baud_tick in reset", baud_tick, 1'b0);
    check_bit("R1", "bit_tick in reset", bit_tick, 1'b0);
    rst_n = 1'b1;
    cur_tag = "R1"; dens = 50;
    run(80);                          // reset config: period 2, ext_en ignored

    cur_tag = "R3"; wr(12'b00_11_00000111);   // internal direct, fields unused
    run(80);
    cur_tag = "R2"; wr(12'b01_01_00000011);   // /4 and /3 -> period 24
    run(24 * 16 + 20);
    cur_tag = "R5"; wr(12'b01_00_00000000);   // divisor 0 acts as 1
    run(80);
    cur_tag = "R3"; dens = 50; wr(12'b10_10_00000101); // external direct
    run(200);
    cur_tag = "R8"; dens = 40; wr(12'b11_00_00000010); // external through generator
    run(300);
    cur_tag = "R8"; dens = 0;                // no external pulses: no ticks
    run(100);
    cur_tag = "R6"; dens = 60; wr(12'b01_10_00000001); // period 32
    run(20);
    wr(12'b01_10_00000001);                  // restart mid-period
    run(30);
    wr(12'b01_00_00000010);                  // switch rate mid-period
    run(200);

    // constrained random configurations
    for (int n = 0; n < 12; n++) begin
      logic [1:0] s;
      logic [1:0] p;
      logic [7:0] d;
      s = 2'($urandom % 4);
      p = 2'($urandom % 4);
      d = 8'($urandom % ((p >= 2) ? 4 : 21));
      dens = 30 + ($urandom % 61);
      cur_tag = "R4";
      wr({s, p, d});
      run(300 + ($urandom % 400));
    end

    // encoder: directed corners then random
    enc_check(16'd0);     enc_check(16'd1);     enc_check(16'd511);
    enc_check(16'd512);   enc_check(16'd513);   enc_check(16'd2047);
    enc_check(16'd2048);  enc_check(16'd8191);  enc_check(16'd8192);
    enc_check(16'd32767); enc_check(16'd32768); enc_check(16'd65535);
    for (int n = 0; n < 150; n++) enc_check(16'($urandom));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule